// File: doc/BRIEF.md
# Masked Register Read-Modify-Write Engine

This block applies a stored list of register updates to a target that is reached over a simple memory-mapped master port. Each update record in a ROM names a 10-bit register address, an 8-bit mask of the bits to change, and 8 bits of new values. For every record the engine reads the target register, keeps every unmasked bit as it was read, replaces the masked bits with the record's values, and writes the merged byte back to the same address.

A controller pulses `start`. The engine then walks the ROM from index 0 to the last index and pulses `done` when the walk is over. Records whose mask is zero cause no bus traffic at all. The ROM is read combinationally: `rom_data` must show the record at `rom_addr` in the same cycle.

Top module: `rmw_engine`

## Requirements
- R1: While reset is held and in the first cycle after reset, `done`, `bus_read` and `bus_write` are low.
- R2: A record is 26 bits. Bits [25:16] are the register address and are driven on `bus_addr`. Bits [15:8] are the mask and bits [7:0] are the data.
- R3: For each record with a non-zero mask, exactly one read and then exactly one write are issued to the record's address, and the write follows the read.
- R4: The written byte equals (read byte AND NOT mask) OR (data AND mask).
- R5: A record with an all-zero mask causes no read and no write, and the register at its address is left unchanged.
- R6: While `bus_waitreq` is high, an asserted `bus_read` or `bus_write` stays asserted, and `bus_addr` and `bus_wdata` hold their values.
- R7: After a read is accepted, no write is issued until `bus_rvalid` has returned the read byte, whatever the read latency.
- R8: Records are taken in ascending ROM index order, from 0 to NUM_REC-1. `rom_addr` only steps up by one or returns to 0.
- R9: `done` is high for exactly one cycle per run. When the final record has a non-zero mask, that cycle is the one right after its write is accepted.
- R10: A `start` pulse that arrives while a run is in progress has no effect.
- R11: `bus_read` and `bus_write` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run through the ROM |
| done | output | 1 | One-cycle end-of-run pulse |
| rom_addr | output | IDX_W | ROM record index |
| rom_data | input | 26 | Record at `rom_addr`, valid in the same cycle |
| bus_addr | output | 10 | Target register address |
| bus_read | output | 1 | Read request |
| bus_write | output | 1 | Write request |
| bus_wdata | output | 8 | Merged write byte |
| bus_rdata | input | 8 | Read return byte |
| bus_waitreq | input | 1 | Target stalls the current request |
| bus_rvalid | input | 1 | `bus_rdata` is valid |

## Verification
A request is accepted on the first rising edge where `bus_waitreq` is low. The next request is presented no earlier than the following cycle. The merged write comes one cycle after the edge that samples `bus_rvalid`. `done` rises one cycle after the final write is accepted. The bench's target model sets its own stall length and read latency. It records the cycle number of every accepted write and every `done` edge, then compares those cycle numbers rather than waiting for fixed delays. Register contents are compared against a model that applies the masked update rule to the records in ROM order. That comparison is made only after `done` and a few idle cycles.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    localparam int ADDR_W = 10;
    localparam int DAT_W  = 8;
    localparam int REC_W  = ADDR_W + 2 * DAT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DAT_W-1:0]  mask;
        logic [DAT_W-1:0]  data;
    } rmw_rec_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_RD,
        S_RWAIT,
        S_WR,
        S_NEXT
    } rmw_state_t;

    function automatic logic [DAT_W-1:0] merge_bits(
        input logic [DAT_W-1:0] old_v,
        input logic [DAT_W-1:0] mask,
        input logic [DAT_W-1:0] data
    );
        return (old_v & ~mask) | (data & mask);
    endfunction

endpackage

// File: rtl/rmw_rec_fetch.sv
module rmw_rec_fetch
    import rmw_pkg::*;
#(
    parameter int NUM_REC = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic             advance,
    input  logic [REC_W-1:0] rom_data,
    output logic [IDX_W-1:0] idx,
    output rmw_rec_t         rec_q,
    output logic             rom_zero,
    output logic             last
);

    rmw_rec_t rom_rec;

    assign rom_rec  = rmw_rec_t'(rom_data);
    assign rom_zero = (rom_rec.mask == '0);
    assign last     = (idx == IDX_W'(NUM_REC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            rec_q <= '0;
        end else begin
            if (clear) begin
                idx <= '0;
            end else if (advance) begin
                idx <= idx + 1'b1;
            end
            if (load) begin
                rec_q <= rom_rec;
            end
        end
    end

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
    import rmw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rom_zero,
    input  logic             last,
    input  rmw_rec_t         rec,
    input  logic             waitreq,
    input  logic             rvalid,
    input  logic [DAT_W-1:0] rdata,
    output logic             clear,
    output logic             load,
    output logic             advance,
    output logic             bus_read,
    output logic             bus_write,
    output logic [DAT_W-1:0] bus_wdata,
    output logic             done
);

    rmw_state_t       state_q, state_d;
    logic [DAT_W-1:0] wdata_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_LOAD;
            S_LOAD:  state_d = rom_zero ? S_NEXT : S_RD;
            S_RD:    if (!waitreq) state_d = S_RWAIT;
            S_RWAIT: if (rvalid) state_d = S_WR;
            S_WR:    if (!waitreq) state_d = S_NEXT;
            S_NEXT:  state_d = last ? S_IDLE : S_LOAD;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_RWAIT && rvalid) begin
                wdata_q <= merge_bits(rdata, rec.mask, rec.data);
            end
        end
    end

    assign clear     = (state_q == S_IDLE) && start;
    assign load      = (state_q == S_LOAD);
    assign advance   = (state_q == S_NEXT) && !last;
    assign done      = (state_q == S_NEXT) && last;
    assign bus_read  = (state_q == S_RD);
    assign bus_write = (state_q == S_WR);
    assign bus_wdata = wdata_q;

endmodule

// File: rtl/rmw_engine.sv
module rmw_engine
    import rmw_pkg::*;
#(
    parameter int NUM_REC = 8,
    localparam int IDX_W  = (NUM_REC > 1) ? $clog2(NUM_REC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              done,
    output logic [IDX_W-1:0]  rom_addr,
    input  logic [REC_W-1:0]  rom_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_read,
    output logic              bus_write,
    output logic [DAT_W-1:0]  bus_wdata,
    input  logic [DAT_W-1:0]  bus_rdata,
    input  logic              bus_waitreq,
    input  logic              bus_rvalid
);

    logic     clear, load, advance, rom_zero, last;
    rmw_rec_t rec_q;

    rmw_rec_fetch #(
        .NUM_REC (NUM_REC),
        .IDX_W   (IDX_W)
    ) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .load     (load),
        .advance  (advance),
        .rom_data (rom_data),
        .idx      (rom_addr),
        .rec_q    (rec_q),
        .rom_zero (rom_zero),
        .last     (last)
    );

    rmw_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rom_zero  (rom_zero),
        .last      (last),
        .rec       (rec_q),
        .waitreq   (bus_waitreq),
        .rvalid    (bus_rvalid),
        .rdata     (bus_rdata),
        .clear     (clear),
        .load      (load),
        .advance   (advance),
        .bus_read  (bus_read),
        .bus_write (bus_write),
        .bus_wdata (bus_wdata),
        .done      (done)
    );

    assign bus_addr = rec_q.addr;

endmodule

// File: rtl/rmw_engine_chk.sv
module rmw_engine_chk
    import rmw_pkg::*;
#(
    parameter int NUM_REC = 8,
    parameter int IDX_W   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic [IDX_W-1:0]  rom_addr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_read,
    input logic              bus_write,
    input logic [DAT_W-1:0]  bus_wdata,
    input logic              bus_waitreq,
    input logic              bus_rvalid
);

    logic rd_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend <= 1'b0;
        end else if (bus_read && !bus_waitreq) begin
            rd_pend <= 1'b1;
        end else if (bus_rvalid) begin
            rd_pend <= 1'b0;
        end
    end

    AST_NO_RDWR: assert property (@(posedge clk) disable iff (rst)
        !(bus_read && bus_write)); // R11

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_read && bus_waitreq) |=> (bus_read && $stable(bus_addr))); // R6

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_write && bus_waitreq) |=> (bus_write && $stable(bus_addr) && $stable(bus_wdata))); // R6

    AST_WR_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        rd_pend |-> !bus_write); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_ROM_ORDER: assert property (@(posedge clk) disable iff (rst)
        (rom_addr != $past(rom_addr)) |->
            ((rom_addr == $past(rom_addr) + 1'b1) || (rom_addr == '0))); // R8

endmodule

bind rmw_engine rmw_engine_chk #(
    .NUM_REC (NUM_REC),
    .IDX_W   (IDX_W)
) u_rmw_chk (
    .clk         (clk),
    .rst         (rst),
    .done        (done),
    .rom_addr    (rom_addr),
    .bus_addr    (bus_addr),
    .bus_read    (bus_read),
    .bus_write   (bus_write),
    .bus_wdata   (bus_wdata),
    .bus_waitreq (bus_waitreq),
    .bus_rvalid  (bus_rvalid)
);

// File: tb/tb_rmw_engine.sv
module tb_rmw_engine;

    localparam int CLK_PERIOD = 10;
    localparam int NREC       = 8;
    localparam int IW         = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        done;
    logic [IW-1:0] rom_addr;
    logic [25:0] rom_data;
    logic [9:0]  bus_addr;
    logic        bus_read, bus_write;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = '0;
    logic        bus_waitreq;
    logic        bus_rvalid = 1'b0;

    logic [25:0] rom [NREC];
    logic [7:0]  mem [1024];
    logic [7:0]  expm [1024];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ws = 0;
    int lat = 1;
    int wcnt = 0;
    int rcnt = 0;
    logic [9:0] raddr;
    int n_rd = 0, n_wr = 0, done_cnt = 0;
    int done_cyc = -1, last_wacc_cyc = -1;
    int viol_hold = 0, viol_rw = 0, viol_order = 0, viol_early = 0, viol_pair = 0;
    logic [9:0] wlog [16];
    logic [9:0] last_rd_addr;
    logic held_r = 0, held_w = 0, pend = 0, prev_done = 0;
    logic [9:0] held_a;
    logic [7:0] held_d;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign rom_data    = rom[rom_addr];
    assign bus_waitreq = (bus_read || bus_write) && (wcnt < ws);

    rmw_engine #(.NUM_REC(NREC)) dut (
        .clk(clk), .rst(rst), .start(start), .done(done),
        .rom_addr(rom_addr), .rom_data(rom_data),
        .bus_addr(bus_addr), .bus_read(bus_read), .bus_write(bus_write),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_waitreq(bus_waitreq), .bus_rvalid(bus_rvalid)
    );

    // Target model and bus monitor
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if ((bus_read || bus_write) && bus_waitreq) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (bus_read && bus_write) viol_rw <= viol_rw + 1;
        if (held_r && !(bus_read && bus_addr == held_a)) viol_hold <= viol_hold + 1;
        if (held_w && !(bus_write && bus_addr == held_a && bus_wdata == held_d))
            viol_hold <= viol_hold + 1;
        held_r <= bus_read && bus_waitreq;
        held_w <= bus_write && bus_waitreq;
        held_a <= bus_addr;
        held_d <= bus_wdata;
        if (bus_read && !bus_waitreq) begin
            n_rd <= n_rd + 1;
            raddr <= bus_addr;
            last_rd_addr <= bus_addr;
            rcnt <= lat;
            pend <= 1'b1;
        end else if (rcnt != 0) begin
            rcnt <= rcnt - 1;
        end
        bus_rvalid <= (rcnt == 1);
        if (rcnt == 1) bus_rdata <= mem[raddr];
        if (bus_rvalid) pend <= 1'b0;
        if (bus_write && !bus_waitreq) begin
            if (pend) viol_early <= viol_early + 1;
            if (n_wr != n_rd - 1 || bus_addr != last_rd_addr) viol_pair <= viol_pair + 1;
            mem[bus_addr] <= bus_wdata;
            if (n_wr < 16) wlog[n_wr] <= bus_addr;
            n_wr <= n_wr + 1;
            last_wacc_cyc <= cyc;
        end
        if (done) begin
            done_cnt <= done_cnt + 1;
            done_cyc <= cyc;
            if (prev_done) viol_order <= viol_order + 1;
        end
        prev_done <= done;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [25:0] mk(input logic [9:0] a, input logic [7:0] m,
                                      input logic [7:0] d);
        return {a, m, d};
    endfunction

    task automatic fill_mem(input int seed);
        for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 37 + seed) ^ (i >> 3));
    endtask

    // Runs the ROM and checks memory, pairing, order and timing.
    task automatic run_set(input string tag, input int ws_in, input int lat_in,
                           input bit mid_start);
        int nexp = 0;
        logic [9:0] eaddr [16];
        int bad = 0;
        int first_bad = -1;
        @(negedge clk);
        ws = ws_in;
        lat = lat_in;
        for (int i = 0; i < 1024; i++) expm[i] = mem[i];
        for (int i = 0; i < NREC; i++) begin
            logic [9:0] a = rom[i][25:16];
            logic [7:0] m = rom[i][15:8];
            logic [7:0] d = rom[i][7:0];
            if (m != 0) begin
                expm[a] = (expm[a] & ~m) | (d & m);
                eaddr[nexp] = a;
                nexp++;
            end
        end
        n_rd = 0; n_wr = 0; done_cnt = 0; done_cyc = -1; last_wacc_cyc = -1;
        viol_hold = 0; viol_rw = 0; viol_order = 0; viol_early = 0; viol_pair = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mid_start) begin
            repeat (4) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (8) @(negedge clk);
        for (int i = 0; i < 1024; i++) begin
            if (mem[i] != expm[i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        chk(bad == 0, "R4", {tag, " merged contents mismatches"}, bad, 0);
        chk(n_rd == nexp && n_wr == nexp, "R3", {tag, " one read and one write per record"},
            n_wr, nexp);
        chk(viol_pair == 0, "R3", {tag, " write not paired with preceding read"}, viol_pair, 0);
        for (int i = 0; i < nexp && i < n_wr; i++)
            chk(wlog[i] == eaddr[i], "R8", {tag, " write address order"}, wlog[i], eaddr[i]);
        chk(viol_hold == 0, "R6", {tag, " request held under waitrequest"}, viol_hold, 0);
        chk(viol_rw == 0, "R11", {tag, " read and write together"}, viol_rw, 0);
        chk(viol_early == 0, "R7", {tag, " write before read data"}, viol_early, 0);
        chk(done_cnt == 1 && viol_order == 0, "R9", {tag, " single done pulse"}, done_cnt, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!done && !bus_read && !bus_write, "R1", "outputs during reset",
            {done, bus_read, bus_write}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !bus_read && !bus_write, "R1", "outputs after reset",
            {done, bus_read, bus_write}, 0);
        repeat (5) @(negedge clk);
        chk(n_rd == 0 && n_wr == 0, "R1", "no traffic without start", n_rd + n_wr, 0);
    endtask

    task automatic t_basic();
        fill_mem(5);
        rom[0] = mk(10'h3FF, 8'hFF, 8'h5A);
        rom[1] = mk(10'h001, 8'h01, 8'h01);
        rom[2] = mk(10'h200, 8'hF0, 8'h00);
        rom[3] = mk(10'h0AA, 8'h0F, 8'hFF);
        rom[4] = mk(10'h155, 8'h80, 8'h80);
        rom[5] = mk(10'h010, 8'h3C, 8'hA5);
        rom[6] = mk(10'h011, 8'hC3, 8'h5A);
        rom[7] = mk(10'h2F0, 8'h55, 8'hFF);
        run_set("basic", 0, 1, 1'b0);
        chk(mem[10'h3FF] == 8'h5A, "R2", "top address field full-mask write", mem[10'h3FF], 8'h5A);
        chk(done_cyc == last_wacc_cyc + 1, "R9", "done one cycle after last write",
            done_cyc, last_wacc_cyc + 1);
    endtask

    task automatic t_stall();
        logic [7:0] orig;
        fill_mem(91);
        orig = mem[10'h155];
        rom[0] = mk(10'h155, 8'hF0, 8'hA5);
        rom[1] = mk(10'h155, 8'h0F, 8'h3C);
        rom[2] = mk(10'h155, 8'h81, 8'h00);
        rom[3] = mk(10'h020, 8'h18, 8'hFF);
        rom[4] = mk(10'h021, 8'hFF, 8'h00);
        rom[5] = mk(10'h022, 8'h02, 8'h02);
        rom[6] = mk(10'h023, 8'h40, 8'h00);
        rom[7] = mk(10'h0F0, 8'hAA, 8'h55);
        run_set("stall", 3, 4, 1'b0);
        chk(mem[10'h155] == 8'h2C, "R4", "chained updates on one register",
            mem[10'h155], 8'h2C);
        chk(done_cyc == last_wacc_cyc + 1, "R9", "done timing under stalls",
            done_cyc, last_wacc_cyc + 1);
        if (orig == 8'h2C) $display("note: chained address already held final value");
    endtask

    task automatic t_skip();
        logic [7:0] keep0, keep5;
        fill_mem(200);
        keep0 = mem[10'h100];
        keep5 = mem[10'h105];
        rom[0] = mk(10'h100, 8'h00, 8'hFF);
        rom[1] = mk(10'h101, 8'hFF, 8'h11);
        rom[2] = mk(10'h102, 8'h0F, 8'h22);
        rom[3] = mk(10'h103, 8'h00, 8'h33);
        rom[4] = mk(10'h104, 8'hF0, 8'h44);
        rom[5] = mk(10'h105, 8'h00, 8'h55);
        rom[6] = mk(10'h106, 8'h01, 8'h66);
        rom[7] = mk(10'h107, 8'h00, 8'h77);
        run_set("skip", 1, 2, 1'b0);
        chk(n_rd == 4, "R5", "zero-mask records issue no read", n_rd, 4);
        chk(mem[10'h100] == keep0 && mem[10'h105] == keep5, "R5",
            "skipped registers unchanged", mem[10'h105], keep5);
    endtask

    task automatic t_busy();
        fill_mem(17);
        for (int i = 0; i < NREC; i++) rom[i] = mk(10'(10'h300 + i), 8'h0F, 8'(i));
        run_set("busy", 1, 2, 1'b1);
        chk(n_wr == NREC, "R10", "start while running starts nothing", n_wr, NREC);
        repeat (20) @(negedge clk);
        chk(n_rd == NREC && done_cnt == 1, "R10", "no second run after busy start",
            n_rd, NREC);
    endtask

    task automatic t_allzero();
        fill_mem(3);
        for (int i = 0; i < NREC; i++) rom[i] = mk(10'(i), 8'h00, 8'hFF);
        run_set("allzero", 0, 1, 1'b0);
        chk(n_rd == 0 && n_wr == 0, "R5", "no bus traffic for all-zero masks", n_rd + n_wr, 0);
    endtask

    initial begin
        for (int i = 0; i < NREC; i++) rom[i] = '0;
        fill_mem(0);
        t_reset();
        t_basic();
        t_stall();
        t_skip();
        t_busy();
        t_allzero();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual hang expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule